// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a parameterised shift/storage register, eight bits wide by default, driven by a single clock. A two-bit mode select picks one of four actions on each rising edge: keep the contents, shift toward the high end, shift toward the low end, or load a new word in parallel. Bit 0 is the "A" end of the register and bit WIDTH-1 is the "H" end.

Parallel data enters and leaves on one shared bidirectional bus. When the drivers are enabled, each bus line carries its stored bit. When either of two active-low enables is high, or whenever the mode is parallel load, the drivers release the bus so that an outside source can present the word to capture. Two end-bit outputs are driven at all times and carry bit 0 and bit WIDTH-1. They let several registers be chained through their serial inputs even while the shared bus is released. An asynchronous active-low clear empties the register.

Top module: `bidir_shift_reg`

## Requirements
- R1: With mode_sel = 2'b00, a rising clock edge leaves every stored bit unchanged.
- R2: With mode_sel = 2'b01, a rising edge moves stored bit i into bit i+1 and loads ser_in_lo into bit 0 (the A end).
- R3: With mode_sel = 2'b10, a rising edge moves stored bit i into bit i-1 and loads ser_in_hi into bit WIDTH-1 (the H end).
- R4: With mode_sel = 2'b11, a rising edge captures the value present on dbus into the register.
- R5: While mode_sel = 2'b11, the block drives no line of dbus, whatever oe_a_n and oe_b_n are.
- R6: While oe_a_n or oe_b_n is high, the block drives no line of dbus. The enables have no effect on holding, shifting, loading or clearing the stored bits.
- R7: While oe_a_n and oe_b_n are both low and mode_sel is not 2'b11, dbus line i shows stored bit i.
- R8: While clr_n is low, the register is zero. Clear acts at once, without waiting for a clock edge, and it overrides every mode including load.
- R9: end_lo always equals stored bit 0 and end_hi always equals stored bit WIDTH-1, independent of the output enables and the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | 00 keep, 01 shift toward H, 10 shift toward A, 11 parallel load |
| oe_a_n | input | 1 | Bus driver enable, active low |
| oe_b_n | input | 1 | Second bus driver enable, active low |
| ser_in_lo | input | 1 | Serial fill for bit 0 when shifting toward H |
| ser_in_hi | input | 1 | Serial fill for bit WIDTH-1 when shifting toward A |
| dbus | inout | WIDTH | Shared parallel bus: read-out when driven, load source when released |
| end_lo | output | 1 | Stored bit 0, always driven |
| end_hi | output | 1 | Stored bit WIDTH-1, always driven |

## Verification
If a stored bit is wrong, the end outputs show it at once when that bit sits at an end, and the bus shows it as soon as the drivers are enabled outside load mode. A wrong shift direction or a wrong fill bit is visible on the read-back that follows the edge that caused it. A driver that fails to release shows up during a load or a disabled interval: the word the bench places on the bus either fails to appear or is captured wrongly. A clear that is late or too weak shows up on the end outputs before the next edge, or on the first read after a load attempted while clear is held low.

// File: rtl/bidir_shift_reg_pkg.sv
package bidir_shift_reg_pkg;
  typedef enum logic [1:0] {
    MODE_KEEP  = 2'b00,
    MODE_TO_HI = 2'b01,
    MODE_TO_LO = 2'b10,
    MODE_LOAD  = 2'b11
  } mode_e;
endpackage

// File: rtl/bidir_shift_core.sv
module bidir_shift_core
  import bidir_shift_reg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  mode_e            mode,
  input  logic             fill_lo,
  input  logic             fill_hi,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] state_q
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] state_d;

  always_comb begin
    unique case (mode)
      MODE_KEEP:  state_d = state_q;
      MODE_TO_HI: state_d = {state_q[TOP-1:0], fill_lo};
      MODE_TO_LO: state_d = {fill_hi, state_q[TOP:1]};
      MODE_LOAD:  state_d = par_in;
      default:    state_d = state_q;
    endcase
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) state_q <= '0;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/bidir_shift_port.sv
module bidir_shift_port
  import bidir_shift_reg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  mode_e            mode,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] state_q,
  output logic             drv_en,
  output logic [WIDTH-1:0] bus_in,
  inout  wire  [WIDTH-1:0] pad
);
  assign drv_en = !oe_a_n && !oe_b_n && (mode != MODE_LOAD);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pad
    assign pad[i]    = drv_en ? state_q[i] : 1'bz;
    assign bus_in[i] = pad[i];
  end
endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import bidir_shift_reg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic [1:0]       mode_sel,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic             ser_in_lo,
  input  logic             ser_in_hi,
  inout  wire  [WIDTH-1:0] dbus,
  output logic             end_lo,
  output logic             end_hi
);
  mode_e            mode;
  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] bus_in;
  logic             drv_en;

  assign mode = mode_e'(mode_sel);

  bidir_shift_core #(.WIDTH(WIDTH)) u_core (
    .clk     (clk),
    .clr_n   (clr_n),
    .mode    (mode),
    .fill_lo (ser_in_lo),
    .fill_hi (ser_in_hi),
    .par_in  (bus_in),
    .state_q (state_q)
  );

  bidir_shift_port #(.WIDTH(WIDTH)) u_port (
    .mode    (mode),
    .oe_a_n  (oe_a_n),
    .oe_b_n  (oe_b_n),
    .state_q (state_q),
    .drv_en  (drv_en),
    .bus_in  (bus_in),
    .pad     (dbus)
  );

  assign end_lo = state_q[0];
  assign end_hi = state_q[WIDTH-1];
endmodule

// File: rtl/bidir_shift_reg_chk.sv
module bidir_shift_reg_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             clr_n,
  input logic [1:0]       mode_sel,
  input logic             oe_a_n,
  input logic             oe_b_n,
  input logic             ser_in_lo,
  input logic             ser_in_hi,
  input logic [WIDTH-1:0] dbus,
  input logic             end_lo,
  input logic             end_hi,
  input logic [WIDTH-1:0] state_q,
  input logic             drv_en
);
  p_keep_r1: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == 2'b00) |=> (state_q == $past(state_q)));

  p_to_hi_r2: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == 2'b01) |=> (state_q == {$past(state_q[WIDTH-2:0]), $past(ser_in_lo)}));

  p_to_lo_r3: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == 2'b10) |=> (state_q == {$past(ser_in_hi), $past(state_q[WIDTH-1:1])}));

  p_load_r4: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == 2'b11) |=> (state_q == $past(dbus)));

  p_release_r5: assert property (@(posedge clk) disable iff (!clr_n)
    (mode_sel == 2'b11) |-> !drv_en);

  p_oe_off_r6: assert property (@(posedge clk) disable iff (!clr_n)
    (oe_a_n || oe_b_n) |-> !drv_en);

  p_readback_r7: assert property (@(posedge clk) disable iff (!clr_n)
    drv_en |-> (dbus == state_q));

  p_clear_r8: assert property (@(posedge clk)
    !clr_n |=> (state_q == '0));

  p_ends_r9: assert property (@(posedge clk) disable iff (!clr_n)
    (end_lo == state_q[0]) && (end_hi == state_q[WIDTH-1]));
endmodule

bind bidir_shift_reg bidir_shift_reg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .clr_n     (clr_n),
  .mode_sel  (mode_sel),
  .oe_a_n    (oe_a_n),
  .oe_b_n    (oe_b_n),
  .ser_in_lo (ser_in_lo),
  .ser_in_hi (ser_in_hi),
  .dbus      (dbus),
  .end_lo    (end_lo),
  .end_hi    (end_hi),
  .state_q   (state_q),
  .drv_en    (drv_en)
);

// File: tb/bidir_shift_reg_test.sv
module bidir_shift_reg_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clr_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic oe_a_n = 1'b0, oe_b_n = 1'b0;
  logic ser_in_lo = 1'b0, ser_in_hi = 1'b0;
  logic tb_drv = 1'b0;
  logic [W-1:0] tb_val = '0;
  wire  [W-1:0] dbus;
  logic end_lo, end_hi;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign dbus = tb_drv ? tb_val : {W{1'bz}};

  bidir_shift_reg #(.WIDTH(W)) uut (
    .clk(clk), .clr_n(clr_n), .mode_sel(mode_sel),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .ser_in_lo(ser_in_lo), .ser_in_hi(ser_in_hi),
    .dbus(dbus), .end_lo(end_lo), .end_hi(end_hi)
  );

  // {mode, ser_lo, ser_hi, oe_a_n, oe_b_n, bus word, expected contents}
  typedef struct packed {
    logic [1:0]   mode;
    logic         s_lo;
    logic         s_hi;
    logic         oa;
    logic         ob;
    logic [W-1:0] word;
    logic [W-1:0] expv;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'hA5},  // R4 load
    '{2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h4B},  // R2 fill 1
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h96},  // R2 fill 0
    '{2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'hCB},  // R3 fill 1
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h65},  // R3 fill 0
    '{2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h65},  // R1 keep, R6
    '{2'b11, 1'b0, 1'b0, 1'b0, 1'b1, 8'h3C, 8'h3C},  // R4 load, R6
    '{2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h79},  // R2 while disabled, R6
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h3C},  // R3 while disabled, R6
    '{2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C}   // R1 keep
  };

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp_v);
    end
  endtask

  // Read contents through the normal interface without a clock edge.
  task automatic peek(string req, logic [W-1:0] exp_v);
    mode_sel = 2'b00; oe_a_n = 1'b0; oe_b_n = 1'b0; tb_drv = 1'b0;
    #0.5;
    check({req, "/R7 bus"}, dbus, exp_v);
    check({req, "/R9 ends"}, {6'd0, end_hi, end_lo}, {6'd0, exp_v[W-1], exp_v[0]});
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset ends", {6'd0, end_hi, end_lo}, 8'd0);
    clr_n = 1'b1;
    @(negedge clk);
    peek("R8 reset", 8'h00);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      mode_sel  = VECS[i].mode;
      ser_in_lo = VECS[i].s_lo;
      ser_in_hi = VECS[i].s_hi;
      oe_a_n    = VECS[i].oa;
      oe_b_n    = VECS[i].ob;
      tb_drv    = (VECS[i].mode == 2'b11);
      tb_val    = VECS[i].word;
      @(posedge clk);
      #1;
      peek($sformatf("vec%0d", i), VECS[i].expv);
    end

    // R6: either enable high releases the bus; the bench's word appears unchanged
    @(negedge clk);
    oe_a_n = 1'b1; tb_drv = 1'b1; tb_val = 8'hC3;
    #0.5 check("R6 oe_a_n float", dbus, 8'hC3);
    oe_a_n = 1'b0; oe_b_n = 1'b1;
    #0.5 check("R6 oe_b_n float", dbus, 8'hC3);
    oe_b_n = 1'b0; tb_drv = 1'b0;

    // R5: load mode releases the bus even with both enables low
    @(negedge clk);
    mode_sel = 2'b11; tb_drv = 1'b1; tb_val = 8'h81;
    #0.5 check("R5 load float", dbus, 8'h81);
    @(posedge clk);
    #1 peek("R4 load 81", 8'h81);

    // R8: asynchronous clear mid-cycle, visible before any edge
    @(posedge clk);
    #1 clr_n = 1'b0;
    #0.5 check("R8 async ends", {6'd0, end_hi, end_lo}, 8'd0);
    // R8: clear overrides a load across several edges
    mode_sel = 2'b11; tb_drv = 1'b1; tb_val = 8'hFF;
    repeat (3) @(posedge clk);
    #1 check("R8 held vs load", {6'd0, end_hi, end_lo}, 8'd0);
    @(negedge clk);
    clr_n = 1'b1;
    peek("R8 after clear", 8'h00);

    // R9: chaining through the end outputs with the bus disabled
    @(negedge clk);
    mode_sel = 2'b01; ser_in_lo = 1'b1; oe_a_n = 1'b1;
    repeat (W) @(posedge clk);
    #1 check("R9 end_hi after fill", {7'd0, end_hi}, 8'd1);
    peek("R2 all ones", 8'hFF);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule